// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Controller

This block sits between the PWM comparator of a synchronous buck converter and the drivers of its two power switches. It turns the PWM request into a high-side enable and a low-side enable. Switching is break-before-make. Neither enable is raised until the opposite switch reports through its own "gate is off" feedback flag that it has stopped conducting. The dead time therefore follows the real turn-off speed of the switches and not a fixed delay.

A feedback flag can get stuck. To keep that from freezing the converter, each wait for feedback is bounded. After a timeout window plus a fixed minimum dead time, the pending gate is enabled anyway.

While soft-start is active, the low-side switch acts like a diode. As soon as the negative-phase-current flag is seen, the low-side gate is dropped, and it stays off until the PWM request goes high again. This keeps a pre-biased output from being discharged. Once soft-start is over, the low side runs in forced-continuous conduction and ignores that flag. A tristate command forces both gates off.

Top module: `gate_deadtime_ctrl`

## Requirements
- R1: `hs_en` and `ls_en` are never high in the same cycle.
- R2: `hs_en` rises only when the previous cycle had `pwm_req` high and either `ls_off_fb` high or an expired wait window.
- R3: `ls_en` rises only when the previous cycle had `pwm_req` low and either `hs_off_fb` high or an expired wait window.
- R4: If the off-feedback of the released gate never arrives, the opposite gate is enabled exactly TMO_CYC+MIN_DEAD+1 clock edges after the released gate dropped.
- R5: While `tristate` is high, both enables are low from the next clock edge on, whatever the other inputs do.
- R6: While `ss_active` is high, a high `neg_cur` with `ls_en` high and `pwm_req` low drops `ls_en` at the next edge. `ls_en` then stays low until `pwm_req` goes high.
- R7: While `ss_active` is low, `neg_cur` has no effect and `ls_en` stays high while `pwm_req` stays low.
- R8: A `pwm_req` held high keeps `hs_en` high indefinitely (100 % duty). A `pwm_req` held low never raises `hs_en` (0 % duty).
- R9: During reset both enables are low.
- R10: `hs_en` falls at the first edge after `pwm_req` goes low. When the feedback answers at once, `ls_en` rises one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_req | input | 1 | PWM request, high selects the high-side switch |
| hs_off_fb | input | 1 | High-side gate drive has fallen below its off level |
| ls_off_fb | input | 1 | Low-side gate drive has fallen below its off level |
| neg_cur | input | 1 | Phase current has gone negative |
| ss_active | input | 1 | Soft-start ramp in progress |
| tristate | input | 1 | Force both gates off |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
The bench models each gate's off-feedback as a delayed copy of that gate's enable. The delay is varied from zero to three cycles, so the measured dead time shows whether the controller really waits on feedback or uses a fixed delay. Stuck-low feedback isolates the timeout path, and the bench checks the exact cycle at which the pending gate is forced on. Long constant requests probe 0 % and 100 % duty. Negative-current pulses are given with soft-start on and with soft-start off, which separates diode emulation from forced-continuous operation. Random segments mix all of these with occasional tristate commands and are compared every cycle against a reference model.

// File: rtl/gdc_pkg.sv
package gdc_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_WAIT_HI,
        ST_HI,
        ST_WAIT_LO,
        ST_LO,
        ST_DIODE
    } gdc_state_e;

    typedef struct packed {
        gdc_state_e st;
        logic       hs_en;
        logic       ls_en;
    } gdc_regs_t;
endpackage

// File: rtl/gdc_wait_timer.sv
module gdc_wait_timer #(
    parameter int TMO_CYC  = 8,
    parameter int MIN_DEAD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic expired
);
    localparam int LIMIT = TMO_CYC + MIN_DEAD;
    localparam int CW    = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    // saturating count of cycles spent in the current wait state
    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (cnt_q != LIM_V)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == LIM_V);

    // R4: the count never passes its limit
    p_cnt_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM_V);
endmodule

// File: rtl/gate_deadtime_ctrl.sv
module gate_deadtime_ctrl
    import gdc_pkg::*;
#(
    parameter int TMO_CYC  = 8,
    parameter int MIN_DEAD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_req,
    input  logic hs_off_fb,
    input  logic ls_off_fb,
    input  logic neg_cur,
    input  logic ss_active,
    input  logic tristate,
    output logic hs_en,
    output logic ls_en
);
    gdc_regs_t r_d, r_q;
    logic      tmr_expired;
    logic      tmr_clr;

    gdc_wait_timer #(
        .TMO_CYC (TMO_CYC),
        .MIN_DEAD(MIN_DEAD)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .expired(tmr_expired)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_OFF:     r_d.st = pwm_req ? ST_WAIT_HI : ST_WAIT_LO;
            ST_WAIT_HI: begin
                if (!pwm_req)                      r_d.st = ST_WAIT_LO;
                else if (ls_off_fb || tmr_expired) r_d.st = ST_HI;
            end
            ST_HI:      if (!pwm_req) r_d.st = ST_WAIT_LO;
            ST_WAIT_LO: begin
                if (pwm_req)                       r_d.st = ST_WAIT_HI;
                else if (hs_off_fb || tmr_expired) r_d.st = ST_LO;
            end
            ST_LO: begin
                if (pwm_req)                    r_d.st = ST_WAIT_HI;
                else if (ss_active && neg_cur)  r_d.st = ST_DIODE;
            end
            ST_DIODE:   if (pwm_req) r_d.st = ST_WAIT_HI;
            default:    r_d.st = ST_OFF;
        endcase
        if (tristate) r_d.st = ST_OFF;
        r_d.hs_en = (r_d.st == ST_HI);
        r_d.ls_en = (r_d.st == ST_LO);
    end

    assign tmr_clr = (r_d.st != r_q.st);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_OFF, hs_en: 1'b0, ls_en: 1'b0};
        else        r_q <= r_d;
    end

    assign hs_en = r_q.hs_en;
    assign ls_en = r_q.ls_en;

    p_no_overlap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    p_hs_after_fb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> $past(pwm_req) && ($past(ls_off_fb) || $past(tmr_expired)));

    p_ls_after_fb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en) |-> !$past(pwm_req) && ($past(hs_off_fb) || $past(tmr_expired)));

    p_tristate_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tristate |=> !hs_en && !ls_en);

    p_diode_cut_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ls_en && ss_active && neg_cur && !pwm_req && !tristate |=> !ls_en);

    p_diode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == ST_DIODE && !pwm_req |=> !ls_en);

    p_fcc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ls_en && !ss_active && !pwm_req && !tristate |=> ls_en);

    p_full_duty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hs_en && pwm_req && !tristate |=> hs_en);

    p_hs_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_req |=> !hs_en);
endmodule

// File: tb/gate_deadtime_ctrl_tb.sv
module gate_deadtime_ctrl_tb;
    localparam int TMO_CYC  = 8;
    localparam int MIN_DEAD = 2;
    localparam int LIMIT    = TMO_CYC + MIN_DEAD;
    localparam int M_OFF = 0, M_WH = 1, M_H = 2, M_WL = 3, M_L = 4, M_DE = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_req = 1'b0, hs_off_fb = 1'b0, ls_off_fb = 1'b0;
    logic neg_cur = 1'b0, ss_active = 1'b0, tristate = 1'b0;
    logic hs_en, ls_en;

    int total = 0, bad = 0;
    int m_st = M_OFF, m_cnt = 0;
    logic m_hs = 1'b0, m_ls = 1'b0;
    int fbd = 1;
    bit stuck = 1'b0;
    logic [3:0] hs_hist = '0, ls_hist = '0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gate_deadtime_ctrl #(.TMO_CYC(TMO_CYC), .MIN_DEAD(MIN_DEAD)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwm_req(pwm_req), .hs_off_fb(hs_off_fb),
        .ls_off_fb(ls_off_fb), .neg_cur(neg_cur), .ss_active(ss_active),
        .tristate(tristate), .hs_en(hs_en), .ls_en(ls_en));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int next_state(int s, int cnt);
        int ns = s;
        bit exp = (cnt == LIMIT);
        case (s)
            M_OFF: ns = pwm_req ? M_WH : M_WL;
            M_WH:  if (!pwm_req) ns = M_WL; else if (ls_off_fb || exp) ns = M_H;
            M_H:   if (!pwm_req) ns = M_WL;
            M_WL:  if (pwm_req) ns = M_WH; else if (hs_off_fb || exp) ns = M_L;
            M_L:   if (pwm_req) ns = M_WH; else if (ss_active && neg_cur) ns = M_DE;
            default: if (pwm_req) ns = M_WH;
        endcase
        if (tristate) ns = M_OFF;
        return ns;
    endfunction

    // one clock: derive feedback, advance model, compare after the edge
    task automatic tick(input string tag);
        int ns;
        bit hz, lz;
        hs_hist = {hs_hist[2:0], hs_en};
        ls_hist = {ls_hist[2:0], ls_en};
        hz = 1'b1; lz = 1'b1;
        for (int i = 0; i <= fbd; i++) begin
            if (hs_hist[i]) hz = 1'b0;
            if (ls_hist[i]) lz = 1'b0;
        end
        hs_off_fb = stuck ? 1'b0 : hz;
        ls_off_fb = stuck ? 1'b0 : lz;
        ns = next_state(m_st, m_cnt);
        if (ns != m_st) m_cnt = 0;
        else if (m_cnt < LIMIT) m_cnt++;
        m_st = ns;
        m_hs = (ns == M_H);
        m_ls = (ns == M_L);
        @(negedge clk);
        chk({hs_en, ls_en} == {m_hs, m_ls}, tag, {hs_en, ls_en}, {m_hs, m_ls});
        chk(!(hs_en && ls_en), "R1 overlap", {hs_en, ls_en}, 0);
    endtask

    initial begin
        #(20 * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk(!hs_en && !ls_en, "R9 reset", {hs_en, ls_en}, 0);
        rst_n = 1'b1;

        // R8: full and zero duty
        fbd = 1; pwm_req = 1'b1;
        repeat (30) tick("R8 high");
        chk(hs_en == 1'b1, "R8 full duty", hs_en, 1);
        pwm_req = 1'b0;
        repeat (30) tick("R8 low");
        chk(hs_en == 1'b0 && ls_en == 1'b1, "R8 zero duty", {hs_en, ls_en}, 1);

        // R4: stuck feedback, forced switch after the window
        pwm_req = 1'b1;
        repeat (20) tick("R4 settle");
        stuck = 1'b1; pwm_req = 1'b0; n = 0;
        do begin tick("R4 stuck lo"); n++; end while (!ls_en && n < 40);
        chk(n == LIMIT + 2, "R4 low side timeout", n, LIMIT + 2);
        pwm_req = 1'b1; n = 0;
        do begin tick("R4 stuck hi"); n++; end while (!hs_en && n < 40);
        chk(n == LIMIT + 2, "R4 high side timeout", n, LIMIT + 2);
        stuck = 1'b0;

        // R10: immediate feedback gives a one-cycle gap
        fbd = 0;
        repeat (5) tick("R10 settle");
        pwm_req = 1'b0;
        tick("R10 fall");
        chk(hs_en == 1'b0 && ls_en == 1'b0, "R10 hs release", {hs_en, ls_en}, 0);
        tick("R10 rise");
        chk(ls_en == 1'b1, "R10 ls after one gap", ls_en, 1);

        // R5: tristate holds both off
        fbd = 1; tristate = 1'b1;
        for (int i = 0; i < 12; i++) begin
            pwm_req = 1'($urandom);
            tick("R5 tristate");
            chk(!hs_en && !ls_en, "R5 both off", {hs_en, ls_en}, 0);
        end
        tristate = 1'b0; pwm_req = 1'b0;
        repeat (8) tick("R5 release");
        chk(ls_en == 1'b1, "R5 resume", ls_en, 1);

        // R6: diode emulation during soft-start
        ss_active = 1'b1; neg_cur = 1'b1;
        tick("R6 cut");
        chk(ls_en == 1'b0, "R6 ls cut", ls_en, 0);
        neg_cur = 1'b0;
        for (int i = 0; i < 6; i++) begin
            tick("R6 hold");
            chk(ls_en == 1'b0, "R6 stays off", ls_en, 0);
        end
        pwm_req = 1'b1;
        repeat (6) tick("R6 next cycle");
        pwm_req = 1'b0;
        repeat (6) tick("R6 resume");
        chk(ls_en == 1'b1, "R6 on again next cycle", ls_en, 1);

        // R7: forced continuous after soft-start
        ss_active = 1'b0; neg_cur = 1'b1;
        for (int i = 0; i < 10; i++) begin
            tick("R7 ignore");
            chk(ls_en == 1'b1, "R7 neg_cur ignored", ls_en, 1);
        end
        neg_cur = 1'b0;

        // random mix, R2 R3 against the model
        for (int seg = 0; seg < 300; seg++) begin
            int len = 1 + int'($urandom_range(0, 14));
            pwm_req   = 1'($urandom);
            ss_active = ($urandom_range(0, 2) == 0);
            tristate  = ($urandom_range(0, 19) == 0);
            fbd       = int'($urandom_range(0, 3));
            stuck     = ($urandom_range(0, 9) == 0);
            for (int k = 0; k < len; k++) begin
                neg_cur = ($urandom_range(0, 3) == 0);
                tick("R2 R3 random");
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule